// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the per-channel transfer registers of a four-channel DMA controller: a 16-bit base address, a 16-bit base count, the current address, the transfer progress, and an 8-bit page and high-page register for each channel. Software reaches the 16-bit registers through an 8-bit access port. One byte pointer, shared by every channel register, selects the low or the high byte and flips after each access. Writing the high byte of either register reloads the channel.

The bank drives a physical transfer address and a transfer length for each channel. A transfer engine reports how far each channel has got through a progress input. Readback is computed from the base values and the progress, so software sees a live address and a live remaining count. The parameter `WIDE` selects the byte-wide instance (0) or the word-wide instance (1). The word-wide instance decodes port numbers shifted right by one, scales addresses by two and doubles the length.

Top module: `dma_chan_regs`

## Requirements
- R1: On a channel access (`acc_sel_i`=0) the register index is (`acc_port_i` >> WIDE) & 0xF. The channel is index >> 1, and index bit 0 picks the address register (0) or the count register (1). Indices 8 to 15 are ignored: they write nothing, read 0 and leave the byte pointer alone.
- R2: One byte pointer serves all channel registers. 0 selects the low byte and 1 the high byte. Each channel read or write uses the current pointer value and then flips it. `ff_clr_i` forces it to 0 and takes priority over a flip. Page accesses never move it.
- R3: A low-byte write replaces bits 7:0 of the addressed base register. A high-byte write replaces bits 15:8 and reloads the channel.
- R4: A reload sets the current address to the base address << WIDE and sets the progress to 0. The current address changes at no other time.
- R5: A count read returns byte ((base_count << WIDE) - progress) >> (WIDE + 8*pointer), in 32-bit wrapping arithmetic.
- R6: An address read returns byte (current ± progress) >> (WIDE + 8*pointer). It adds when `mode_dir_i` for that channel is 0 and subtracts when it is 1.
- R7: The transfer length of each channel is (base_count + 1) << WIDE.
- R8: Progress changes only when `prog_vld_i` is high for that channel. It takes `prog_i`, capped at the transfer length.
- R9: Page (`acc_sel_i`=1) and high-page (`acc_sel_i`=2) accesses decode `acc_port_i[2:0]`: offset 1 is channel 2, 2 is channel 3, 3 is channel 1 and 7 is channel 0. Other offsets ignore writes and read 0, and `acc_sel_i`=3 reads 0 and writes nothing.
- R10: The physical address of a channel is {high_page[6:0], page[7:0], current_address[15:0]}, 31 bits. High-page bit 7 is stored and read back but does not reach the address.
- R11: Reset clears all base, current, progress and page registers and the byte pointer, so the length reads 1 << WIDE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_wr_i | input | 1 | Register write strobe |
| acc_rd_i | input | 1 | Register read strobe |
| acc_sel_i | input | 2 | Target: 0 channel, 1 page, 2 high page, 3 none |
| acc_port_i | input | 8 | Port number within the target |
| acc_wdata_i | input | 8 | Write byte |
| acc_rdata_o | output | 8 | Read byte, combinational on the current access |
| ff_clr_i | input | 1 | Clear the byte pointer |
| mode_dir_i | input | NUM_CH | Per-channel address direction, 1 = decrement |
| prog_vld_i | input | NUM_CH | Per-channel progress update strobe |
| prog_i | input | NUM_CH*18 | Per-channel progress value |
| phys_addr_o | output | NUM_CH*31 | Per-channel physical transfer address |
| xfer_len_o | output | NUM_CH*18 | Per-channel transfer length |

## Verification
Both the byte-wide and the word-wide instance are swept over every channel and both registers. Each register gets its own distinct 16-bit value, so a swapped channel, a swapped register or a missing port shift shows as a wrong byte on readback. The progress is then moved in both directions and pushed past the length, which separates add from subtract and checks the cap. The pointer is probed with ignored indices, page traffic and the clear input. Every page offset is written with valid channels first and invalid offsets afterwards, so a decode that lets an invalid offset through corrupts a visible address.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int ADDR_W = 16;
  localparam int PROG_W = 18;
  localparam int PHYS_W = 31;
  localparam int RB_W   = 32;

  typedef enum logic [1:0] {
    SEL_CHAN  = 2'd0,
    SEL_PAGE  = 2'd1,
    SEL_HPAGE = 2'd2,
    SEL_NONE  = 2'd3
  } acc_sel_e;

  typedef struct packed {
    logic       vld;
    logic [1:0] ch;
  } page_map_t;

  // page port offset to channel
  function automatic page_map_t page_chan(input logic [2:0] off);
    page_map_t m;
    case (off)
      3'd1:    m = '{vld: 1'b1, ch: 2'd2};
      3'd2:    m = '{vld: 1'b1, ch: 2'd3};
      3'd3:    m = '{vld: 1'b1, ch: 2'd1};
      3'd7:    m = '{vld: 1'b1, ch: 2'd0};
      default: m = '{vld: 1'b0, ch: 2'd0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= 1'b0;
    else if (clr_i)  ptr_o <= 1'b0;
    else if (step_i) ptr_o <= ~ptr_o;
  end

  assert_ptr_flip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> (ptr_o != $past(ptr_o)));
  assert_ptr_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_o == 1'b0));
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot import dma_chan_pkg::*; #(
  parameter int WIDE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              reg_cnt_i,
  input  logic [7:0]        wdata_i,
  input  logic              page_we_i,
  input  logic              hpage_we_i,
  input  logic              dir_i,
  input  logic              prog_vld_i,
  input  logic [PROG_W-1:0] prog_i,
  output logic [7:0]        page_o,
  output logic [7:0]        hpage_o,
  output logic [PHYS_W-1:0] phys_o,
  output logic [PROG_W-1:0] len_o,
  output logic [RB_W-1:0]   addr_rb_o,
  output logic [RB_W-1:0]   cnt_rb_o
);
  localparam int CUR_W = ADDR_W + WIDE;

  logic [ADDR_W-1:0] base_addr_q, base_cnt_q, reload_addr;
  logic [CUR_W-1:0]  cur_q;
  logic [PROG_W-1:0] prog_q;
  logic [RB_W-1:0]   cur_w, prog_w;

  // base address as it stands after this cycle's high-byte write
  assign reload_addr = reg_cnt_i ? base_addr_q : {wdata_i, base_addr_q[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_q       <= '0;
      prog_q      <= '0;
      page_o      <= '0;
      hpage_o     <= '0;
    end else begin
      if (wr_lo_i) begin
        if (reg_cnt_i) base_cnt_q[7:0]  <= wdata_i;
        else           base_addr_q[7:0] <= wdata_i;
      end
      if (wr_hi_i) begin
        if (reg_cnt_i) base_cnt_q[15:8]  <= wdata_i;
        else           base_addr_q[15:8] <= wdata_i;
        cur_q  <= CUR_W'(reload_addr) << WIDE;
        prog_q <= '0;
      end else if (prog_vld_i) begin
        prog_q <= (prog_i > len_o) ? len_o : prog_i;
      end
      if (page_we_i)  page_o  <= wdata_i;
      if (hpage_we_i) hpage_o <= wdata_i;
    end
  end

  assign len_o     = (PROG_W'(base_cnt_q) + PROG_W'(1)) << WIDE;
  assign phys_o    = {hpage_o[6:0], page_o, cur_q[ADDR_W-1:0]};
  assign cur_w     = RB_W'(cur_q);
  assign prog_w    = RB_W'(prog_q);
  assign addr_rb_o = dir_i ? (cur_w - prog_w) : (cur_w + prog_w);
  assign cnt_rb_o  = (RB_W'(base_cnt_q) << WIDE) - prog_w;

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (prog_q == '0) && (cur_q == (CUR_W'(base_addr_q) << WIDE)));
  assert_cur_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(cur_q));
  assert_prog_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_vld_i && !wr_hi_i) |=> (prog_q <= $past(len_o)));
  assert_prog_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_vld_i && !wr_hi_i) |=> $stable(prog_q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_chan_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int WIDE   = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_wr_i,
  input  logic                     acc_rd_i,
  input  logic [1:0]               acc_sel_i,
  input  logic [7:0]               acc_port_i,
  input  logic [7:0]               acc_wdata_i,
  output logic [7:0]               acc_rdata_o,
  input  logic                     ff_clr_i,
  input  logic [NUM_CH-1:0]        mode_dir_i,
  input  logic [NUM_CH-1:0]        prog_vld_i,
  input  logic [NUM_CH*PROG_W-1:0] prog_i,
  output logic [NUM_CH*PHYS_W-1:0] phys_addr_o,
  output logic [NUM_CH*PROG_W-1:0] xfer_len_o
);
  localparam int IDX_W = 4;

  acc_sel_e         sel;
  logic [IDX_W-1:0] idx;
  logic             ptr_q, chan_hit, chan_step, chan_wr, page_hit;
  page_map_t        pm;
  logic [7:0]       page_q  [NUM_CH];
  logic [7:0]       hpage_q [NUM_CH];
  logic [RB_W-1:0]  addr_rb [NUM_CH];
  logic [RB_W-1:0]  cnt_rb  [NUM_CH];
  logic [RB_W-1:0]  rb;
  logic [4:0]       shamt;

  assign sel       = acc_sel_e'(acc_sel_i);
  assign idx       = IDX_W'(acc_port_i >> WIDE);
  assign chan_hit  = (sel == SEL_CHAN) && (32'(idx[3:1]) < NUM_CH);
  assign chan_step = chan_hit && (acc_wr_i || acc_rd_i);
  assign chan_wr   = chan_hit && acc_wr_i;
  assign pm        = page_chan(acc_port_i[2:0]);
  assign page_hit  = pm.vld && (32'(pm.ch) < NUM_CH);

  dma_byte_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ff_clr_i),
    .step_i (chan_step),
    .ptr_o  (ptr_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic reg_me, pg_me;
    assign reg_me = chan_wr && (idx[3:1] == 3'(c));
    assign pg_me  = acc_wr_i && page_hit && (pm.ch == 2'(c));

    dma_chan_slot #(.WIDE(WIDE)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_lo_i    (reg_me && !ptr_q),
      .wr_hi_i    (reg_me && ptr_q),
      .reg_cnt_i  (idx[0]),
      .wdata_i    (acc_wdata_i),
      .page_we_i  (pg_me && (sel == SEL_PAGE)),
      .hpage_we_i (pg_me && (sel == SEL_HPAGE)),
      .dir_i      (mode_dir_i[c]),
      .prog_vld_i (prog_vld_i[c]),
      .prog_i     (prog_i[c*PROG_W +: PROG_W]),
      .page_o     (page_q[c]),
      .hpage_o    (hpage_q[c]),
      .phys_o     (phys_addr_o[c*PHYS_W +: PHYS_W]),
      .len_o      (xfer_len_o[c*PROG_W +: PROG_W]),
      .addr_rb_o  (addr_rb[c]),
      .cnt_rb_o   (cnt_rb[c])
    );
  end

  always_comb begin
    rb = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_hit && idx[3:1] == 3'(c))
        rb = idx[0] ? cnt_rb[c] : addr_rb[c];
      if (page_hit && pm.ch == 2'(c)) begin
        if (sel == SEL_PAGE)  rb = RB_W'(page_q[c]);
        if (sel == SEL_HPAGE) rb = RB_W'(hpage_q[c]);
      end
    end
  end

  // page bytes are returned unshifted
  assign shamt       = (sel == SEL_CHAN) ? (5'(WIDE) + (ptr_q ? 5'd8 : 5'd0)) : 5'd0;
  assign acc_rdata_o = 8'(rb >> shamt);

  assert_ptr_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_sel_i != 2'(SEL_CHAN) && !ff_clr_i) |=> $stable(ptr_q));
  assert_page_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_sel_i != 2'(SEL_CHAN) && !pm.vld) |-> (acc_rdata_o == 8'd0));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int PW = 18;
  localparam int AW = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]       wr, rd, clr;
  logic [1:0]       sel [2];
  logic [7:0]       port [2];
  logic [7:0]       wd [2];
  logic [7:0]       rdat [2];
  logic [NC-1:0]    dir [2];
  logic [NC-1:0]    pv [2];
  logic [NC*PW-1:0] pval [2];
  logic [NC*AW-1:0] phys [2];
  logic [NC*PW-1:0] len [2];

  dma_chan_regs #(.NUM_CH(NC), .WIDE(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_wr_i(wr[0]), .acc_rd_i(rd[0]),
    .acc_sel_i(sel[0]), .acc_port_i(port[0]), .acc_wdata_i(wd[0]),
    .acc_rdata_o(rdat[0]), .ff_clr_i(clr[0]), .mode_dir_i(dir[0]),
    .prog_vld_i(pv[0]), .prog_i(pval[0]), .phys_addr_o(phys[0]), .xfer_len_o(len[0]));

  dma_chan_regs #(.NUM_CH(NC), .WIDE(1)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .acc_wr_i(wr[1]), .acc_rd_i(rd[1]),
    .acc_sel_i(sel[1]), .acc_port_i(port[1]), .acc_wdata_i(wd[1]),
    .acc_rdata_o(rdat[1]), .ff_clr_i(clr[1]), .mode_dir_i(dir[1]),
    .prog_vld_i(pv[1]), .prog_i(pval[1]), .phys_addr_o(phys[1]), .xfer_len_o(len[1]));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_ba [2][NC];
  logic [15:0] m_bc [2][NC];
  logic [31:0] m_cur [2][NC];
  logic [31:0] m_pr [2][NC];
  logic [7:0]  m_pg [2][NC];
  logic [7:0]  m_hp [2][NC];
  bit          m_ptr [2];
  bit          m_dir [2][NC];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int page_map(input int off);
    case (off)
      1: return 2;
      2: return 3;
      3: return 1;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] m_len(input int u, input int c);
    return (32'(m_bc[u][c]) + 32'd1) << u;
  endfunction

  function automatic logic [7:0] exp_byte(input int u, input int c, input int cnt);
    logic [31:0] v;
    if (cnt != 0) v = (32'(m_bc[u][c]) << u) - m_pr[u][c];
    else if (m_dir[u][c]) v = m_cur[u][c] - m_pr[u][c];
    else v = m_cur[u][c] + m_pr[u][c];
    return 8'(v >> (u + (m_ptr[u] ? 8 : 0)));
  endfunction

  task automatic acc(input int u, input bit w, input bit r, input logic [1:0] s,
                     input logic [7:0] p, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    wr[u] = w; rd[u] = r; sel[u] = s; port[u] = p; wd[u] = d;
    #1 q = rdat[u];
    @(posedge clk);
    #1 wr[u] = 1'b0; rd[u] = 1'b0; sel[u] = 2'd3;
  endtask

  task automatic chan_wr(input int u, input int c, input int cnt, input logic [7:0] d);
    logic [7:0] q;
    acc(u, 1, 0, 2'd0, 8'((c*2 + cnt) << u), d, q);
    if (!m_ptr[u]) begin
      if (cnt != 0) m_bc[u][c][7:0] = d; else m_ba[u][c][7:0] = d;
    end else begin
      if (cnt != 0) m_bc[u][c][15:8] = d; else m_ba[u][c][15:8] = d;
      m_cur[u][c] = 32'(m_ba[u][c]) << u;
      m_pr[u][c] = 0;
    end
    m_ptr[u] = !m_ptr[u];
  endtask

  task automatic chan_rd(input int u, input int c, input int cnt, input string req);
    logic [7:0] q;
    acc(u, 0, 1, 2'd0, 8'((c*2 + cnt) << u), 8'h00, q);
    chk(req, $sformatf("u%0d ch%0d reg%0d ptr%0d read", u, c, cnt, m_ptr[u]), q, exp_byte(u, c, cnt));
    m_ptr[u] = !m_ptr[u];
  endtask

  task automatic check_outs(input int u, input int c, input string req);
    logic [31:0] e;
    e = {1'b0, m_hp[u][c][6:0], m_pg[u][c], m_cur[u][c][15:0]};
    chk(req, $sformatf("u%0d ch%0d phys", u, c), phys[u][c*AW +: AW], e[30:0]);
    chk("R7", $sformatf("u%0d ch%0d len", u, c), len[u][c*PW +: PW], m_len(u, c));
  endtask

  task automatic set_prog(input int u, input int c, input logic [PW-1:0] v);
    @(negedge clk);
    pv[u][c] = 1'b1; pval[u][c*PW +: PW] = v;
    @(posedge clk);
    #1 pv[u][c] = 1'b0;
    m_pr[u][c] = (32'(v) > m_len(u, c)) ? m_len(u, c) : 32'(v);
  endtask

  task automatic set_dir(input int u, input int c, input bit d);
    @(negedge clk);
    dir[u][c] = d; m_dir[u][c] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    for (int u = 0; u < 2; u++) begin
      wr[u] = 0; rd[u] = 0; clr[u] = 0; sel[u] = 2'd3; port[u] = 0; wd[u] = 0;
      dir[u] = '0; pv[u] = '0; pval[u] = '0; m_ptr[u] = 0;
      for (int c = 0; c < NC; c++) begin
        m_ba[u][c] = 0; m_bc[u][c] = 0; m_cur[u][c] = 0; m_pr[u][c] = 0;
        m_pg[u][c] = 0; m_hp[u][c] = 0; m_dir[u][c] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c < NC; c++) check_outs(u, c, "R11");
      chan_rd(u, 0, 0, "R11");
      chan_rd(u, 3, 1, "R11");
    end

    // R3 R5 R6 R1 R10: full register sweep, distinct values
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < NC; c++)
        for (int cnt = 0; cnt < 2; cnt++) begin
          logic [15:0] v;
          v = 16'(c*16'h1111 + cnt*16'h0F0F + u*16'h3C3C + 16'h1234);
          chan_wr(u, c, cnt, v[7:0]);
          chan_wr(u, c, cnt, v[15:8]);
          check_outs(u, c, "R3");
        end
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < NC; c++)
        for (int cnt = 0; cnt < 2; cnt++) begin
          chan_rd(u, c, cnt, cnt != 0 ? "R5" : "R1");
          chan_rd(u, c, cnt, cnt != 0 ? "R5" : "R6");
        end

    // R8 R6 R5: progress in both directions and saturation
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < NC; c++) begin
        set_prog(u, c, PW'(5 + 3*c));
        chan_rd(u, c, 0, "R6"); chan_rd(u, c, 0, "R6");
        chan_rd(u, c, 1, "R5"); chan_rd(u, c, 1, "R5");
        set_dir(u, c, 1'b1);
        chan_rd(u, c, 0, "R6"); chan_rd(u, c, 0, "R6");
        set_prog(u, c, '1);
        chan_rd(u, c, 1, "R8"); chan_rd(u, c, 1, "R8");
        chan_rd(u, c, 0, "R8"); chan_rd(u, c, 0, "R8");
        check_outs(u, c, "R10");
      end

    // R4: reload by count high byte clears progress
    for (int u = 0; u < 2; u++) begin
      chan_wr(u, 2, 1, 8'h40);
      chan_wr(u, 2, 1, 8'h01);
      chan_rd(u, 2, 1, "R4"); chan_rd(u, 2, 1, "R4");
      chan_rd(u, 2, 0, "R4"); chan_rd(u, 2, 0, "R4");
      check_outs(u, 2, "R4");
    end

    // R1: indices 8..15 ignored, no pointer move
    for (int u = 0; u < 2; u++) begin
      acc(u, 1, 0, 2'd0, 8'(8 << u), 8'hAA, q);
      acc(u, 0, 1, 2'd0, 8'(9 << u), 8'h00, q);
      chk("R1", $sformatf("u%0d idx9 read", u), q, 0);
      chan_rd(u, 0, 0, "R1");
      chan_rd(u, 0, 0, "R1");
      for (int c = 0; c < NC; c++) check_outs(u, c, "R1");
    end

    // R2: clear input and page traffic vs pointer
    for (int u = 0; u < 2; u++) begin
      chan_wr(u, 1, 0, 8'h5A);
      @(negedge clk); clr[u] = 1'b1;
      @(posedge clk); #1 clr[u] = 1'b0;
      m_ptr[u] = 0;
      chan_rd(u, 1, 0, "R2");
      acc(u, 0, 1, 2'd1, 8'd1, 8'h00, q);
      chan_rd(u, 1, 0, "R2");
    end

    // R9 R10: page and high page decode
    for (int u = 0; u < 2; u++) begin
      for (int hi = 0; hi < 2; hi++)
        for (int off = 0; off < 8; off++)
          if (page_map(off) >= 0) begin
            logic [7:0] d;
            d = 8'(off*8'h11 + hi*8'h80 + u*8'h06);
            acc(u, 1, 0, hi ? 2'd2 : 2'd1, 8'(off), d, q);
            if (hi != 0) m_hp[u][page_map(off)] = d; else m_pg[u][page_map(off)] = d;
          end
      for (int hi = 0; hi < 2; hi++)
        for (int off = 0; off < 8; off++)
          if (page_map(off) < 0) acc(u, 1, 0, hi ? 2'd2 : 2'd1, 8'(off), 8'hFF, q);
      acc(u, 1, 0, 2'd3, 8'd1, 8'hEE, q);
      chk("R9", $sformatf("u%0d no-target read", u), q, 0);
      for (int hi = 0; hi < 2; hi++)
        for (int off = 0; off < 8; off++) begin
          logic [7:0] e;
          acc(u, 0, 1, hi ? 2'd2 : 2'd1, 8'(off), 8'h00, q);
          if (page_map(off) < 0) e = 0;
          else e = hi ? m_hp[u][page_map(off)] : m_pg[u][page_map(off)];
          chk("R9", $sformatf("u%0d hi%0d off%0d read", u, hi, off), q, e);
        end
      for (int c = 0; c < NC; c++) check_outs(u, c, "R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule